// File: doc/BRIEF.md
# Status Register and Program Protection Unit

This unit keeps the configuration and state byte of a serial memory device and rules on every request to change the array or the configuration. The command front end decodes serial opcodes into single-cycle strobes and hands them over, together with the target address, the level of the external protect pin and a busy flag from the array programming engine. The unit answers each program request with a one-cycle grant or deny pulse and always presents the current status byte for the read-status command.

Array protection splits the address space into four equal quarters, chosen by the two most significant address bits. A two-bit lock field selects how many of the top quarters are shielded. The lock field and the pin-enable bit represent non-volatile cells: they have no reset and keep their value across the power-up reset, while the write-enable latch and the busy state are cleared by it.

A small state machine sequences the work. Its states are `S_IDLE` (waiting for commands), `S_ARM` (grant issued, waiting for the engine to raise busy), `S_RUN` (programming, waiting for busy to drop) and `S_SRW` (one-cycle commit of a status write). The transitions are: `S_IDLE`→`S_ARM` on a granted program request, `S_ARM`→`S_RUN` when busy is high, `S_RUN`→`S_IDLE` when busy is low, `S_IDLE`→`S_SRW` on an accepted status write, and `S_SRW`→`S_IDLE` unconditionally. All other cases hold the current state.

Top module: `srwp_unit`

## Requirements
- R1: The status byte layout is bit 7 pin-enable, bits 6..4 unused, bit 3 lock-high, bit 2 lock-low, bit 1 write-enable latch, bit 0 busy. After reset the latch, busy and unused bits read 0, and the pin-enable and lock bits keep the values written before the reset.
- R2: A set-latch strobe sets status bit 1, and a clear-latch strobe clears it. Both are sampled in `S_IDLE`, and the result is visible in the cycle after the strobe.
- R3: An accepted status write copies data bits 7, 3 and 2 into pin-enable, lock-high and lock-low, and ignores data bits 6..4 and 1..0. It spends exactly one cycle in `S_SRW`, during which the status byte reads 8'hFF. It then returns to idle with the latch cleared.
- R4: A status write with the latch clear is refused, and the status byte is unchanged.
- R5: When pin-enable is 1 and the protect pin is low, a status write is refused and the latch keeps its value. When pin-enable is 0, the level of the protect pin has no effect.
- R6: A program request in `S_IDLE` with the latch set, aimed at an unlocked quarter, produces a one-cycle grant pulse in the cycle after the request.
- R7: The quarter is addr[ADDR_W-1:ADDR_W-2]. The locked set depends on {lock-high,lock-low}: 00 locks no quarter, 01 locks quarter 3, 10 locks quarters 2 and 3, and 11 locks all quarters.
- R8: A request aimed at a locked quarter produces a one-cycle deny pulse. No busy state starts (bit 0 stays 0), and the latch is cleared.
- R9: A program request with the latch clear is denied.
- R10: While the state is not `S_IDLE`, the status byte reads 8'hFF.
- R11: When busy falls in `S_RUN`, the unit returns to `S_IDLE` with the latch cleared.
- R12: While the state is not `S_IDLE`, a program request is denied and clears the latch. Status writes and latch strobes in that period have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset (asynchronous assert) |
| cmd_set_pel | input | 1 | Set-latch strobe |
| cmd_clr_pel | input | 1 | Clear-latch strobe |
| cmd_wr_status | input | 1 | Status write strobe |
| wr_status_data | input | 8 | Byte carried by the status write |
| cmd_program | input | 1 | Program request strobe |
| prog_addr | input | ADDR_W | Target array address of the request |
| pp_pin | input | 1 | External protect pin, high allows writes |
| prog_busy | input | 1 | Busy flag from the array programming engine |
| status_byte | output | 8 | Current status byte |
| prog_grant | output | 1 | One-cycle grant of a program request |
| prog_deny | output | 1 | One-cycle denial of a program request |

## Verification
The hardest situation to reach is a command that arrives while a program cycle is running. It has to be shown that the latch strobes and the status write change nothing, even though the status byte masks everything with 8'hFF during that time. The stimulus first grants a request and holds the engine's busy flag high. It then issues a set-latch strobe, a second program request and a status write with different lock bits. After busy drops, it reads the restored status byte to prove that the configuration survived. The retention of the non-volatile bits across a power-up reset is checked the same way: the bits are written, reset is applied, and the status byte is read back.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_RUN  = 2'd2,
        S_SRW  = 2'd3
    } srwp_state_e;

    // bit positions in the status byte
    localparam int BIT_PPEN = 7;
    localparam int BIT_BLH  = 3;
    localparam int BIT_BLL  = 2;
    localparam int BIT_PEL  = 1;
    localparam int BIT_PIP  = 0;
    localparam int STAT_W   = 8;

    typedef struct packed {
        logic       pin_en;
        logic [1:0] lock;
    } srwp_nv_t;

endpackage

// File: rtl/srwp_lock_decode.sv
module srwp_lock_decode #(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        lock,
    output logic              locked
);
    localparam int SEG_W = 2;

    logic [SEG_W-1:0] seg;
    logic             unused_low;

    assign seg        = addr[ADDR_W-1 -: SEG_W];
    assign unused_low = ^addr[ADDR_W-SEG_W-1:0];

    always_comb begin
        unique case (lock)
            2'b00:   locked = 1'b0;
            2'b01:   locked = (seg == 2'b11);
            2'b10:   locked = seg[1];
            default: locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/srwp_nv_regs.sv
module srwp_nv_regs
    import srwp_pkg::*;
(
    input  logic     clk,
    input  logic     wr_en,
    input  srwp_nv_t wr_data,
    output srwp_nv_t cfg
);
    // non-volatile cells: no reset, value survives the power-up reset
    srwp_nv_t cfg_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cfg_q <= wr_data;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/srwp_ctrl.sv
module srwp_ctrl
    import srwp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_set,
    input  logic        cmd_clr,
    input  logic        cmd_wrsr,
    input  srwp_nv_t    wrsr_data,
    input  logic        cmd_prog,
    input  logic        locked,
    input  logic        pin_ok,
    input  logic        prog_busy,
    output srwp_state_e state,
    output logic        pel,
    output logic        grant,
    output logic        deny,
    output logic        nv_we,
    output srwp_nv_t    nv_wdata
);
    srwp_state_e state_q, state_d;
    logic        pel_q, pel_d;
    logic        grant_q, grant_d;
    logic        deny_q, deny_d;
    srwp_nv_t    hold_q, hold_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and registered outputs
    always_comb begin
        state_d = state_q;
        pel_d   = pel_q;
        grant_d = 1'b0;
        deny_d  = 1'b0;
        hold_d  = hold_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_prog) begin
                    if (pel_q && !locked) begin
                        grant_d = 1'b1;
                        state_d = S_ARM;
                    end else begin
                        deny_d = 1'b1;
                        pel_d  = 1'b0;
                    end
                end else if (cmd_wrsr) begin
                    if (pel_q && pin_ok) begin
                        hold_d  = wrsr_data;
                        state_d = S_SRW;
                    end
                end else if (cmd_set) begin
                    pel_d = 1'b1;
                end else if (cmd_clr) begin
                    pel_d = 1'b0;
                end
            end
            S_ARM: begin
                if (cmd_prog) begin
                    deny_d = 1'b1;
                    pel_d  = 1'b0;
                end
                if (prog_busy) begin
                    state_d = S_RUN;
                end
            end
            S_RUN: begin
                if (cmd_prog) begin
                    deny_d = 1'b1;
                    pel_d  = 1'b0;
                end
                if (!prog_busy) begin
                    pel_d   = 1'b0;
                    state_d = S_IDLE;
                end
            end
            S_SRW: begin
                if (cmd_prog) begin
                    deny_d = 1'b1;
                end
                pel_d   = 1'b0;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pel_q   <= 1'b0;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
            hold_q  <= '0;
        end else begin
            pel_q   <= pel_d;
            grant_q <= grant_d;
            deny_q  <= deny_d;
            hold_q  <= hold_d;
        end
    end

    assign state    = state_q;
    assign pel      = pel_q;
    assign grant    = grant_q;
    assign deny     = deny_q;
    assign nv_we    = (state_q == S_SRW);
    assign nv_wdata = hold_q;

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_q && deny_q));

    p_deny_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        deny_q |-> !pel_q);

    p_grant_needs_pel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> $past(pel_q));

    p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !prog_busy) |=> (state_q == S_IDLE && !pel_q));

    p_srw_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SRW) |=> (state_q == S_IDLE && !pel_q));

endmodule

// File: rtl/srwp_unit.sv
module srwp_unit
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_set_pel,
    input  logic              cmd_clr_pel,
    input  logic              cmd_wr_status,
    input  logic [7:0]        wr_status_data,
    input  logic              cmd_program,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic              pp_pin,
    input  logic              prog_busy,
    output logic [7:0]        status_byte,
    output logic              prog_grant,
    output logic              prog_deny
);
    srwp_state_e state;
    srwp_nv_t    nv_cfg, nv_wdata, wr_fields;
    logic        pel, locked, pin_ok, nv_we, pip;
    logic        unused_data;

    assign wr_fields.pin_en = wr_status_data[BIT_PPEN];
    assign wr_fields.lock   = {wr_status_data[BIT_BLH], wr_status_data[BIT_BLL]};
    assign unused_data      = ^{wr_status_data[6:4], wr_status_data[1:0]};

    // protect pin only counts when the enable bit is set
    assign pin_ok = !nv_cfg.pin_en || pp_pin;

    srwp_lock_decode #(.ADDR_W(ADDR_W)) u_lock (
        .addr   (prog_addr),
        .lock   (nv_cfg.lock),
        .locked (locked)
    );

    srwp_nv_regs u_nv (
        .clk     (clk),
        .wr_en   (nv_we),
        .wr_data (nv_wdata),
        .cfg     (nv_cfg)
    );

    srwp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_set   (cmd_set_pel),
        .cmd_clr   (cmd_clr_pel),
        .cmd_wrsr  (cmd_wr_status),
        .wrsr_data (wr_fields),
        .cmd_prog  (cmd_program),
        .locked    (locked),
        .pin_ok    (pin_ok),
        .prog_busy (prog_busy),
        .state     (state),
        .pel       (pel),
        .grant     (prog_grant),
        .deny      (prog_deny),
        .nv_we     (nv_we),
        .nv_wdata  (nv_wdata)
    );

    assign pip = (state != S_IDLE);

    always_comb begin
        if (pip) begin
            status_byte = '1;
        end else begin
            status_byte          = '0;
            status_byte[BIT_PPEN] = nv_cfg.pin_en;
            status_byte[BIT_BLH]  = nv_cfg.lock[1];
            status_byte[BIT_BLL]  = nv_cfg.lock[0];
            status_byte[BIT_PEL]  = pel;
        end
    end

    p_busy_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (status_byte == 8'hFF));

    p_nv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !nv_we |=> $stable(nv_cfg));

    p_grant_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_grant |-> !$past(locked));

endmodule

// File: tb/sim_srwp_unit.sv
module sim_srwp_unit;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_set_pel, cmd_clr_pel, cmd_wr_status, cmd_program;
    logic [7:0]    wr_status_data;
    logic [AW-1:0] prog_addr;
    logic          pp_pin, prog_busy;
    logic [7:0]    status_byte;
    logic          prog_grant, prog_deny;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int         q_req[$];
    logic [9:0] q_exp[$];
    logic [9:0] q_msk[$];

    always #5 clk = ~clk;

    srwp_unit #(.ADDR_W(AW)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_set_pel    (cmd_set_pel),
        .cmd_clr_pel    (cmd_clr_pel),
        .cmd_wr_status  (cmd_wr_status),
        .wr_status_data (wr_status_data),
        .cmd_program    (cmd_program),
        .prog_addr      (prog_addr),
        .pp_pin         (pp_pin),
        .prog_busy      (prog_busy),
        .status_byte    (status_byte),
        .prog_grant     (prog_grant),
        .prog_deny      (prog_deny)
    );

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q_exp.size() > 0) begin
                int         r;
                logic [9:0] e, m, o;
                r = q_req.pop_front();
                e = q_exp.pop_front();
                m = q_msk.pop_front();
                o = {prog_grant, prog_deny, status_byte};
                checks++;
                if ((o & m) !== (e & m)) begin
                    errors++;
                    $display("FAIL R%0d: got grant/deny/status=%b/%b/%h expected %b/%b/%h (mask %h)",
                             r, o[9], o[8], o[7:0], e[9], e[8], e[7:0], m[7:0]);
                end
            end
        end
    end

    task automatic clr_cmds();
        cmd_set_pel   = 1'b0;
        cmd_clr_pel   = 1'b0;
        cmd_wr_status = 1'b0;
        cmd_program   = 1'b0;
    endtask

    // driver: advance one edge, drop strobes, queue expected outputs
    task automatic cyc(input int r, input logic g, input logic d,
                       input logic [7:0] st, input logic [7:0] mk);
        @(posedge clk);
        #1;
        clr_cmds();
        q_req.push_back(r);
        q_exp.push_back({g, d, st});
        q_msk.push_back({2'b11, mk});
    endtask

    task automatic set_pel(input int r, input logic [7:0] st, input logic [7:0] mk);
        cmd_set_pel = 1'b1;
        cyc(r, 1'b0, 1'b0, st, mk);
    endtask

    task automatic wrsr(input int r, input logic [7:0] data, input logic [7:0] st);
        cmd_wr_status  = 1'b1;
        wr_status_data = data;
        cyc(r, 1'b0, 1'b0, st, 8'hFF);
    endtask

    task automatic prog(input int r, input logic [AW-1:0] a, input logic g,
                        input logic d, input logic [7:0] st);
        cmd_program = 1'b1;
        prog_addr   = a;
        cyc(r, g, d, st, 8'hFF);
    endtask

    // engine busy cycle after a grant, ending in the idle status byte
    task automatic busy_cycle(input logic [7:0] idle_st);
        prog_busy = 1'b1;
        cyc(10, 1'b0, 1'b0, 8'hFF, 8'hFF);   // R10
        prog_busy = 1'b0;
        cyc(11, 1'b0, 1'b0, idle_st, 8'hFF); // R11
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n          = 1'b0;
        clr_cmds();
        wr_status_data = '0;
        prog_addr      = '0;
        pp_pin         = 1'b1;
        prog_busy      = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state (non-volatile bits unknown yet, masked off)
        cyc(1, 1'b0, 1'b0, 8'h00, 8'h73);
        // R2: set and clear the latch
        set_pel(2, 8'h02, 8'h73);
        cmd_clr_pel = 1'b1;
        cyc(2, 1'b0, 1'b0, 8'h00, 8'h73);
        // R3: first configuration write, unused data bits ignored
        set_pel(2, 8'h02, 8'h73);
        wrsr(3, 8'hF7, 8'hFF);
        cyc(3, 1'b0, 1'b0, 8'h84, 8'hFF);
        // R4: refused write without the latch
        wrsr(4, 8'h0C, 8'h84);
        cyc(4, 1'b0, 1'b0, 8'h84, 8'hFF);
        // R5: pin low with enable set refuses, latch kept
        set_pel(2, 8'h86, 8'hFF);
        pp_pin = 1'b0;
        wrsr(5, 8'h00, 8'h86);
        cyc(5, 1'b0, 1'b0, 8'h86, 8'hFF);
        pp_pin = 1'b1;
        wrsr(5, 8'h08, 8'hFF);
        cyc(5, 1'b0, 1'b0, 8'h08, 8'hFF);
        // R5: pin ignored while enable is clear
        pp_pin = 1'b0;
        set_pel(2, 8'h0A, 8'hFF);
        wrsr(5, 8'h8C, 8'hFF);
        cyc(5, 1'b0, 1'b0, 8'h8C, 8'hFF);
        pp_pin = 1'b1;
        // R1: non-volatile bits survive reset
        rst_n = 1'b0;
        cyc(1, 1'b0, 1'b0, 8'h8C, 8'hFF);
        rst_n = 1'b1;
        cyc(1, 1'b0, 1'b0, 8'h8C, 8'hFF);
        // R8: whole array locked, deny clears latch, no busy
        set_pel(2, 8'h8E, 8'hFF);
        prog(8, 13'h0000, 1'b0, 1'b1, 8'h8C);
        cyc(8, 1'b0, 1'b0, 8'h8C, 8'hFF);
        // lock upper quarter
        set_pel(2, 8'h8E, 8'hFF);
        wrsr(3, 8'h04, 8'hFF);
        cyc(3, 1'b0, 1'b0, 8'h04, 8'hFF);
        // R7: quarter 3 locked, quarter 2 open
        set_pel(2, 8'h06, 8'hFF);
        prog(7, 13'h1800, 1'b0, 1'b1, 8'h04);
        set_pel(2, 8'h06, 8'hFF);
        prog(7, 13'h17FF, 1'b1, 1'b0, 8'hFF);
        // R10 and R12: commands during the program cycle
        prog_busy = 1'b1;
        cyc(10, 1'b0, 1'b0, 8'hFF, 8'hFF);
        set_pel(12, 8'hFF, 8'hFF);
        prog(12, 13'h0000, 1'b0, 1'b1, 8'hFF);
        wrsr(12, 8'h8C, 8'hFF);
        prog_busy = 1'b0;
        cyc(12, 1'b0, 1'b0, 8'h04, 8'hFF);
        // R9: latch clear denies
        prog(9, 13'h0000, 1'b0, 1'b1, 8'h04);
        // R6 and R11: clean grant and completion
        set_pel(2, 8'h06, 8'hFF);
        prog(6, 13'h0000, 1'b1, 1'b0, 8'hFF);
        busy_cycle(8'h04);
        // R7: upper half locked
        set_pel(2, 8'h06, 8'hFF);
        wrsr(3, 8'h08, 8'hFF);
        cyc(3, 1'b0, 1'b0, 8'h08, 8'hFF);
        set_pel(2, 8'h0A, 8'hFF);
        prog(7, 13'h1000, 1'b0, 1'b1, 8'h08);
        set_pel(2, 8'h0A, 8'hFF);
        prog(7, 13'h0FFF, 1'b1, 1'b0, 8'hFF);
        busy_cycle(8'h08);
        // R7: nothing locked, top address granted
        set_pel(2, 8'h0A, 8'hFF);
        wrsr(3, 8'h00, 8'hFF);
        cyc(3, 1'b0, 1'b0, 8'h00, 8'hFF);
        set_pel(2, 8'h02, 8'hFF);
        prog(6, 13'h1FFF, 1'b1, 1'b0, 8'hFF);
        busy_cycle(8'h00);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule